// File: doc/BRIEF.md
# Supply Voltage Level Measurement Sequencer

This block is the digital control for an on-chip supply voltage level detector. Software reaches it through a 4-bit control/status register on a simple write/read bus. Writing a nonzero threshold code selects one of three compare levels and arms a single measurement. The block then waits for the slow 256 Hz timing signal. It enables the analog comparator from the first rising edge of that signal up to the following falling edge. At that falling edge it latches whether the supply sits above or below the selected level.

The analog comparator, the reference ladder and the 256 Hz source are outside the block and appear as plain inputs. The 256 Hz signal is a level input that is already synchronous to `clk`. Its edges are found by comparing it with its value one cycle earlier. The comparator output is asynchronous and passes through a synchronizer. Sleep mode shuts the detector down and cancels any measurement that is armed or running.

Top module: `supply_level_seq`

## Requirements
- R1: After reset, `rdData`, `levelSel` and `anaEn` are all zero.
- R2: `rdData` bit 3 is the result, bit 2 is busy, and bits 1:0 are the stored level code. `levelSel` always equals bits 1:0. Written values in bits 3:2 have no effect.
- R3: Write a nonzero level code while idle and awake. The code is stored, and busy reads 1 from the next cycle. `anaEn` stays 0 until a rising edge of `tick256` is seen.
- R4: Write level code 00 while idle. The code 00 is stored, busy stays 0, no measurement runs on later `tick256` edges, and the result is unchanged.
- R5: Once armed, the cycle in which `tick256` is 1 after being 0 in the previous cycle makes `anaEn` read 1 from the next cycle.
- R6: While `anaEn` is 1, the cycle in which `tick256` is 0 after being 1 loads the result: 1 means the supply is below the selected level, 0 means above. Busy and `anaEn` read 0 from the next cycle.
- R7: The result changes only when a measurement completes. The previous result stays readable while a new measurement is armed or running.
- R8: Writes that arrive while busy is 1 are ignored: the level code and the running measurement stay unchanged.
- R9: While `sleepMode` is 1, writes are ignored. Busy and `anaEn` read 0 from the next cycle, and the result is kept. An armed or running measurement is discarded and does not resume when sleep ends.
- R10: `cmpOut` passes through two flops before it is sampled. The result takes the comparator level present two clock edges before the ending edge, so a change in the final cycle is not seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 4 | Register write data |
| rdData | output | 4 | Register read data {result, busy, level[1:0]} |
| tick256 | input | 1 | 256 Hz timing signal, synchronous to clk |
| sleepMode | input | 1 | Sleep indicator; disables the detector |
| cmpOut | input | 1 | Asynchronous comparator output, 1 = supply below level |
| levelSel | output | 2 | Level code driven to the reference ladder |
| anaEn | output | 1 | Analog comparator enable |

## Verification
The bench writes while busy, in the middle of a measurement. A design that accepted that write would move `levelSel` or restart the sequence. It also writes code 00 and then toggles `tick256`; a design that treated 00 as a start command would raise busy or `anaEn`. It flips the comparator in the same cycle as the ending falling edge. A design without the two-flop delay would latch the new value. Sleep is asserted both while a measurement runs and while one is only armed. A design that froze instead of aborting, or that resumed the stale command on wake, would drive `anaEn` after sleep ends.

// File: rtl/supply_level_pkg.sv
`timescale 1ns/1ps
package supply_level_pkg;
  // Sequencer states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_MEAS  = 2'd2
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadLevel;
    logic sampleResult;
  } dpStrobe_t;
endpackage

// File: rtl/supply_level_dp.sv
`timescale 1ns/1ps
module supply_level_dp
  import supply_level_pkg::*;
#(
  parameter int LVL_W       = 2,
  parameter int SYNC_STAGES = 2   // minimum 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [LVL_W-1:0] wrLevel,
  input  logic             tickIn,
  input  logic             cmpRaw,
  output logic [LVL_W-1:0] level,
  output logic             result,
  output logic             tickRise,
  output logic             tickFall
);
  logic                   tickQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   cmpSync;

  // Edge detection on the slow timing signal
  always_ff @(posedge clk) begin
    if (!rstN) tickQ <= 1'b0;
    else       tickQ <= tickIn;
  end
  assign tickRise = tickIn & ~tickQ;
  assign tickFall = ~tickIn & tickQ;

  // Comparator synchronizer chain
  generate
    if (SYNC_STAGES > 1) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], cmpRaw};
      end
    end else begin : g_sync_one
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= cmpRaw;
      end
    end
  endgenerate
  assign cmpSync = syncQ[SYNC_STAGES-1];

  // Level code register
  always_ff @(posedge clk) begin
    if (!rstN)                 level <= '0;
    else if (strobe.loadLevel) level <= wrLevel;
  end

  // Result register: only a completed measurement updates it
  always_ff @(posedge clk) begin
    if (!rstN)                    result <= 1'b0;
    else if (strobe.sampleResult) result <= cmpSync;
  end

  // R7: result holds unless a measurement ends
  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.sampleResult |=> $stable(result));

  // R8: level code holds unless a write is accepted
  p_hold_level_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadLevel |=> $stable(level));
endmodule

// File: rtl/supply_level_ctrl.sv
`timescale 1ns/1ps
module supply_level_ctrl
  import supply_level_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      wrNonZero,
  input  logic      sleepMode,
  input  logic      tickRise,
  input  logic      tickFall,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      anaEn
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (sleepMode) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (wrEn) begin
            strobe.loadLevel = 1'b1;
            if (wrNonZero) stateNext = ST_ARMED;
          end
        end
        ST_ARMED: if (tickRise) stateNext = ST_MEAS;
        ST_MEAS: begin
          if (tickFall) begin
            strobe.sampleResult = 1'b1;
            stateNext           = ST_IDLE;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy  = (state != ST_IDLE);
  assign anaEn = (state == ST_MEAS);

  // R3: accepted nonzero write arms, comparator still off
  p_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy && !sleepMode && wrNonZero) |=> (busy && !anaEn));

  // R4: a zero code starts nothing
  p_zero_code_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy && !sleepMode && !wrNonZero) |=> !busy);

  // R5: rising edge while armed enables the comparator
  p_rise_enables_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !anaEn && tickRise && !sleepMode) |=> anaEn);

  // R6: falling edge while measuring ends the measurement
  p_fall_ends_r6: assert property (@(posedge clk) disable iff (!rstN)
    (anaEn && tickFall && !sleepMode) |=> (!busy && !anaEn));

  // R9: sleep forces the detector off
  p_sleep_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    sleepMode |=> (!busy && !anaEn));
endmodule

// File: rtl/supply_level_seq.sv
`timescale 1ns/1ps
module supply_level_seq
  import supply_level_pkg::*;
#(
  parameter int LVL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [LVL_W+1:0]     wrData,
  output logic [LVL_W+1:0]     rdData,
  input  logic                 tick256,
  input  logic                 sleepMode,
  input  logic                 cmpOut,
  output logic [LVL_W-1:0]     levelSel,
  output logic                 anaEn
);
  localparam int REG_W = LVL_W + 2;

  dpStrobe_t        strobe;
  logic             busy;
  logic             result;
  logic             tickRise;
  logic             tickFall;
  logic [LVL_W-1:0] level;
  logic             unusedWrHi;

  assign unusedWrHi = ^wrData[REG_W-1:LVL_W];

  supply_level_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrNonZero (|wrData[LVL_W-1:0]),
    .sleepMode (sleepMode),
    .tickRise  (tickRise),
    .tickFall  (tickFall),
    .strobe    (strobe),
    .busy      (busy),
    .anaEn     (anaEn)
  );

  supply_level_dp #(
    .LVL_W       (LVL_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrLevel  (wrData[LVL_W-1:0]),
    .tickIn   (tick256),
    .cmpRaw   (cmpOut),
    .level    (level),
    .result   (result),
    .tickRise (tickRise),
    .tickFall (tickFall)
  );

  assign rdData   = {result, busy, level};
  assign levelSel = level;

  // R8: a write during busy leaves the level code alone
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn) |=> $stable(levelSel));

  // R9: a write during sleep leaves the level code alone
  p_ignore_sleep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sleepMode && wrEn) |=> $stable(levelSel));
endmodule

// File: tb/supply_level_seq_tb.sv
`timescale 1ns/1ps
module supply_level_seq_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn;
  logic [3:0] wrData;
  logic [3:0] rdData;
  logic       tick256;
  logic       sleepMode;
  logic       cmpOut;
  logic [1:0] levelSel;
  logic       anaEn;

  always #2.5 clk = ~clk;

  supply_level_seq u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .tick256(tick256), .sleepMode(sleepMode), .cmpOut(cmpOut),
    .levelSel(levelSel), .anaEn(anaEn)
  );

  typedef struct {
    logic [3:0] rd;
    logic       ana;
    string      tag;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  // Driver side: queue what the outputs must show in this cycle
  task automatic expectOut(input logic [3:0] rd, input logic ana, input string tag);
    item_t it;
    it.rd = rd; it.ana = ana; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [3:0] d);
    wrEn = 1'b1; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  // Monitor: compare queued items against the outputs away from the edge
  always @(negedge clk) begin
    #0.5;
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rdData !== it.rd || anaEn !== it.ana || levelSel !== it.rd[1:0]) begin
        errors++;
        $display("FAIL %s: rd=%b ana=%b lvl=%b expected rd=%b ana=%b lvl=%b",
                 it.tag, rdData, anaEn, levelSel, it.rd, it.ana, it.rd[1:0]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrData = 4'h0;
    tick256 = 1'b0; sleepMode = 1'b0; cmpOut = 1'b0;
    repeat (3) step();
    rstN = 1'b1;
    expectOut(4'b0000, 1'b0, "R1 reset state");
    step();
    expectOut(4'b0000, 1'b0, "R1 idle after reset");

    // Arm at level 2 with junk in bits 3:2
    writeReg(4'b1110);
    expectOut(4'b0110, 1'b0, "R3 busy next cycle, R2 bits 3:2 not writable");
    step(); step();
    expectOut(4'b0110, 1'b0, "R3 waits for rising edge");

    // Run with comparator reporting below
    cmpOut = 1'b1;
    tick256 = 1'b1;
    step();
    expectOut(4'b0110, 1'b1, "R5 enable after rising edge");
    writeReg(4'b0001);
    expectOut(4'b0110, 1'b1, "R8 write while busy ignored");
    step();
    expectOut(4'b0110, 1'b1, "R8 measurement still running");
    tick256 = 1'b0;
    step();
    expectOut(4'b1010, 1'b0, "R6 result below, busy cleared");

    // Zero code
    writeReg(4'b0000);
    expectOut(4'b1000, 1'b0, "R4 zero code stored, no busy");
    tick256 = 1'b1; step();
    tick256 = 1'b0; step();
    expectOut(4'b1000, 1'b0, "R4 no measurement on tick");

    // Level 1, comparator above; old result visible meanwhile
    cmpOut = 1'b0;
    writeReg(4'b0001);
    expectOut(4'b1101, 1'b0, "R7 old result while armed");
    tick256 = 1'b1; step();
    expectOut(4'b1101, 1'b1, "R7 old result while measuring");
    step(); step();
    tick256 = 1'b0; step();
    expectOut(4'b0001, 1'b0, "R6 result above");

    // Synchronizer corner: comparator flips with the ending edge
    cmpOut = 1'b1;
    writeReg(4'b0010);
    step(); step();
    tick256 = 1'b1; step();
    expectOut(4'b0110, 1'b1, "R5 enable at level 2");
    step(); step();
    tick256 = 1'b0; cmpOut = 1'b0; step();
    expectOut(4'b1010, 1'b0, "R10 late comparator change not seen");

    // Sleep during a running measurement
    writeReg(4'b0011);
    expectOut(4'b1111, 1'b0, "R3 armed at level 3");
    step(); step();
    tick256 = 1'b1; step();
    expectOut(4'b1111, 1'b1, "R5 running at level 3");
    sleepMode = 1'b1; step();
    expectOut(4'b1011, 1'b0, "R9 sleep aborts measurement");
    writeReg(4'b0001);
    expectOut(4'b1011, 1'b0, "R9 write in sleep ignored");
    sleepMode = 1'b0;
    tick256 = 1'b0; step(); step();
    tick256 = 1'b1; step();
    expectOut(4'b1011, 1'b0, "R9 no resume after sleep");
    tick256 = 1'b0; step();
    expectOut(4'b1011, 1'b0, "R9 result kept after sleep");

    // Sleep while only armed
    writeReg(4'b0010);
    expectOut(4'b1110, 1'b0, "R3 armed again");
    sleepMode = 1'b1; step();
    expectOut(4'b1010, 1'b0, "R9 sleep discards pending command");
    sleepMode = 1'b0;
    tick256 = 1'b1; step();
    expectOut(4'b1010, 1'b0, "R9 pending command stays discarded");
    tick256 = 1'b0; step();
    step();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule